// File: doc/BRIEF.md
# Programmable Line Clamp Pulse Generator

This block drives three active-low timing strobes for each video line: an optical-black clamp, a dummy clamp and a pre-blank. Each strobe is shaped by a starting level and two pixel positions. At each of those positions the strobe inverts. The positions are counted in pixel clocks from the line-start pulse. The clamp or blank window is the interval in which the strobe is low.

Each strobe owns a bank of four stored shapes. An external region controller drives a 2-bit select per strobe, and the block samples those selects on each line start. The chosen shapes are copied into an active set that stays fixed for the whole line. Different parts of a frame readout can therefore use different clamp and blank patterns without a glitch partway through a line. Register writes land in the banks at any time. They reach an output only through the copy made at the next line start.

Top module: `line_clamp_gen`

## Requirements
- R1: A 12-bit pixel counter is 0 in the cycle after a clock edge with `line_start_i` high. It then rises by one per clock, and a new line start restarts it at 0 from any value.
- R2: After reset, and until the first line start, all three bits of `pulse_n_o` are high.
- R3: At pixel 0 a strobe shows the stored start level `wr_pol_i` of its selected shape, unless a toggle position equals 0.
- R4: A strobe inverts from the pixel equal to its first toggle position onward.
- R5: A strobe inverts again from the pixel equal to its second toggle position. When the two positions are equal, only one inversion occurs.
- R6: The counter saturates at 4095. A toggle at 4095 takes effect once, and the strobe then holds until the next line start.
- R7: `seq_sel_i` is sampled only on the line-start edge. A change during a line has no effect on that line.
- R8: A write alters a strobe only from the next line start. A write issued in the same cycle as a line start does not affect the line that this edge begins.
- R9: Strobe codes on `wr_sig_i` are 0 for the optical-black clamp, 1 for the dummy clamp and 2 for the pre-blank. A write with code 3 changes no stored shape.
- R10: Strobe i (bit i of `pulse_n_o`) uses only the select field `seq_sel_i[2i+1:2i]` and its own bank, independently of the other two strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_start_i | input | 1 | One-cycle line-start strobe |
| wr_en_i | input | 1 | Write one stored shape |
| wr_sig_i | input | 2 | Target strobe code (0 OB clamp, 1 dummy clamp, 2 pre-blank) |
| wr_seq_i | input | 2 | Target shape slot 0..3 |
| wr_pol_i | input | 1 | Start level of the shape |
| wr_tog1_i | input | 12 | First toggle pixel |
| wr_tog2_i | input | 12 | Second toggle pixel |
| seq_sel_i | input | 6 | Shape select, 2 bits per strobe |
| pulse_n_o | output | 3 | Active-low strobes: bit 0 OB clamp, 1 dummy clamp, 2 pre-blank |

## Verification
The bench targets toggle positions at pixel 0, equal toggle pairs, and a toggle at 4095 on a line left to run into saturation. Getting these wrong would show up as a strobe that starts at the wrong level, a strobe that inverts twice and returns to its start level, or a strobe that keeps flipping once the counter is pinned. It also changes selects and writes shapes in the middle of a line and on the line-start edge itself. A design that read the banks live would glitch within the line. A design that let the write bypass the copy would shift the current line's window early. Writes with strobe code 3 and randomly shaped short lines with random selects check that the banks are separate and that the counter restarts properly.

// File: rtl/lcg_pkg.sv
package lcg_pkg;
  localparam int PIX_W   = 12;
  localparam int NUM_SIG = 3;
  localparam int NUM_SEQ = 4;
  localparam int SIG_W   = $clog2(NUM_SIG + 1);
  localparam int SEQ_W   = $clog2(NUM_SEQ);

  typedef logic [PIX_W-1:0] pix_t;

  typedef struct packed {
    logic pol;
    pix_t tog1;
    pix_t tog2;
  } seq_cfg_t;

  localparam pix_t     PIX_MAX = '1;
  localparam seq_cfg_t CFG_RST = '{pol: 1'b1, tog1: PIX_MAX, tog2: PIX_MAX};

  // equal toggles collapse to a single inversion
  function automatic logic cfg_hit(seq_cfg_t c, pix_t p);
    return (p == c.tog1) || (p == c.tog2);
  endfunction
endpackage

// File: rtl/lcg_pix_counter.sv
module lcg_pix_counter
  import lcg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_start_i,
  output pix_t cnt_o,
  output pix_t nxt_o,
  output logic step_o
);
  pix_t cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= PIX_MAX;
    else if (line_start_i)      cnt_q <= '0;
    else if (cnt_q != PIX_MAX)  cnt_q <= cnt_q + 1'b1;
  end

  assign step_o = !line_start_i && (cnt_q != PIX_MAX);
  assign nxt_o  = line_start_i ? '0 : cnt_q + 1'b1;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/lcg_seq_bank.sv
module lcg_seq_bank
  import lcg_pkg::*;
#(
  parameter int SIG_IDX = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SIG_W-1:0] wr_sig_i,
  input  logic [SEQ_W-1:0] wr_seq_i,
  input  seq_cfg_t         wr_cfg_i,
  input  logic [SEQ_W-1:0] sel_i,
  output seq_cfg_t         rd_cfg_o
);
  seq_cfg_t bank_q [NUM_SEQ];
  logic     wr_hit;

  assign wr_hit = wr_en_i && (wr_sig_i == SIG_W'(SIG_IDX));

  for (genvar e = 0; e < NUM_SEQ; e++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 bank_q[e] <= CFG_RST;
      else if (wr_hit && wr_seq_i == SEQ_W'(e))    bank_q[e] <= wr_cfg_i;
    end
  end

  assign rd_cfg_o = bank_q[sel_i];
endmodule

// File: rtl/lcg_pulse_shaper.sv
module lcg_pulse_shaper
  import lcg_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     line_start_i,
  input  logic     step_i,
  input  pix_t     nxt_i,
  input  seq_cfg_t sel_cfg_i,
  output seq_cfg_t act_cfg_o,
  output logic     pulse_n_o
);
  seq_cfg_t act_q;
  logic     lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= CFG_RST;
      lvl_q <= 1'b1;
    end else if (line_start_i) begin
      // shape frozen for the whole line
      act_q <= sel_cfg_i;
      lvl_q <= sel_cfg_i.pol ^ cfg_hit(sel_cfg_i, '0);
    end else if (step_i) begin
      lvl_q <= lvl_q ^ cfg_hit(act_q, nxt_i);
    end
  end

  assign act_cfg_o = act_q;
  assign pulse_n_o = lvl_q;
endmodule

// File: rtl/line_clamp_gen.sv
module line_clamp_gen
  import lcg_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     line_start_i,
  input  logic                     wr_en_i,
  input  logic [SIG_W-1:0]         wr_sig_i,
  input  logic [SEQ_W-1:0]         wr_seq_i,
  input  logic                     wr_pol_i,
  input  logic [PIX_W-1:0]         wr_tog1_i,
  input  logic [PIX_W-1:0]         wr_tog2_i,
  input  logic [NUM_SIG*SEQ_W-1:0] seq_sel_i,
  output logic [NUM_SIG-1:0]       pulse_n_o
);
  pix_t     pix_cnt;
  pix_t     pix_nxt;
  logic     pix_step;
  seq_cfg_t wr_cfg;
  seq_cfg_t sel_cfg [NUM_SIG];
  seq_cfg_t act_cfg [NUM_SIG];

  logic [NUM_SIG*PIX_W-1:0] act_tog1_flat;
  logic [NUM_SIG*PIX_W-1:0] act_tog2_flat;
  logic [NUM_SIG-1:0]       act_pol_flat;

  assign wr_cfg = '{pol: wr_pol_i, tog1: wr_tog1_i, tog2: wr_tog2_i};

  lcg_pix_counter u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .line_start_i(line_start_i),
    .cnt_o       (pix_cnt),
    .nxt_o       (pix_nxt),
    .step_o      (pix_step)
  );

  for (genvar i = 0; i < NUM_SIG; i++) begin : g_sig
    lcg_seq_bank #(.SIG_IDX(i)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_en_i (wr_en_i),
      .wr_sig_i(wr_sig_i),
      .wr_seq_i(wr_seq_i),
      .wr_cfg_i(wr_cfg),
      .sel_i   (seq_sel_i[i*SEQ_W +: SEQ_W]),
      .rd_cfg_o(sel_cfg[i])
    );

    lcg_pulse_shaper u_shp (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .line_start_i(line_start_i),
      .step_i      (pix_step),
      .nxt_i       (pix_nxt),
      .sel_cfg_i   (sel_cfg[i]),
      .act_cfg_o   (act_cfg[i]),
      .pulse_n_o   (pulse_n_o[i])
    );

    assign act_tog1_flat[i*PIX_W +: PIX_W] = act_cfg[i].tog1;
    assign act_tog2_flat[i*PIX_W +: PIX_W] = act_cfg[i].tog2;
    assign act_pol_flat[i]                 = act_cfg[i].pol;
  end
endmodule

// File: rtl/lcg_checker.sv
module lcg_checker
  import lcg_pkg::*;
(
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     line_start_i,
  input logic [NUM_SIG-1:0]       pulse_n_o,
  input pix_t                     cnt_i,
  input logic [NUM_SIG*PIX_W-1:0] act_tog1_i,
  input logic [NUM_SIG*PIX_W-1:0] act_tog2_i,
  input logic [NUM_SIG-1:0]       act_pol_i
);
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           seen_q <= 1'b0;
    else if (line_start_i) seen_q <= 1'b1;
  end

  p_cnt_restart_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_i |=> cnt_i == '0);

  p_cnt_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!line_start_i && cnt_i != PIX_MAX) |=> cnt_i == $past(cnt_i) + 1'b1);

  p_idle_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> pulse_n_o == '1);

  p_sat_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!line_start_i && cnt_i == PIX_MAX) |=> $stable(pulse_n_o) && cnt_i == PIX_MAX);

  p_sel_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_start_i |=> $stable(act_tog1_i) && $stable(act_tog2_i) && $stable(act_pol_i));

  for (genvar i = 0; i < NUM_SIG; i++) begin : g_chk
    // inversions only at a programmed position (R4, R5)
    p_flip_at_tog_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !line_start_i |=> (pulse_n_o[i] == $past(pulse_n_o[i]))
                        || cnt_i == act_tog1_i[i*PIX_W +: PIX_W]
                        || cnt_i == act_tog2_i[i*PIX_W +: PIX_W]);
  end
endmodule

bind line_clamp_gen lcg_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .line_start_i(line_start_i),
  .pulse_n_o   (pulse_n_o),
  .cnt_i       (pix_cnt),
  .act_tog1_i  (act_tog1_flat),
  .act_tog2_i  (act_tog2_flat),
  .act_pol_i   (act_pol_flat)
);

// File: tb/line_clamp_gen_tb_top.sv
module line_clamp_gen_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        line_start_i;
  logic        wr_en_i;
  logic [1:0]  wr_sig_i;
  logic [1:0]  wr_seq_i;
  logic        wr_pol_i;
  logic [11:0] wr_tog1_i;
  logic [11:0] wr_tog2_i;
  logic [5:0]  seq_sel_i;
  logic [2:0]  pulse_n_o;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  bit m_pol [3][4];
  int m_t1  [3][4];
  int m_t2  [3][4];
  bit a_pol [3];
  int a_t1  [3];
  int a_t2  [3];
  int pix  = 0;
  bit seen = 0;

  always #4 clk_i = ~clk_i;

  line_clamp_gen dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_start_i(line_start_i),
    .wr_en_i(wr_en_i), .wr_sig_i(wr_sig_i), .wr_seq_i(wr_seq_i),
    .wr_pol_i(wr_pol_i), .wr_tog1_i(wr_tog1_i), .wr_tog2_i(wr_tog2_i),
    .seq_sel_i(seq_sel_i), .pulse_n_o(pulse_n_o)
  );

  function automatic bit exp_lvl(bit pol, int t1, int t2, int p);
    return pol ^ (p >= t1) ^ ((p >= t2) && (t2 != t1));
  endfunction

  task automatic check(input string tag, input logic [2:0] got, input logic [2:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s pix=%0d got=%b exp=%b", tag, pix, got, exp);
    end
  endtask

  task automatic check_pix(input string tag);
    logic [2:0] e;
    if (!seen) e = 3'b111;
    else for (int i = 0; i < 3; i++) e[i] = exp_lvl(a_pol[i], a_t1[i], a_t2[i], pix);
    check(tag, pulse_n_o, e);
  endtask

  // one clock: inputs were driven at the previous negedge
  task automatic tick(input string tag);
    @(posedge clk_i);
    if (line_start_i) begin
      for (int i = 0; i < 3; i++) begin
        a_pol[i] = m_pol[i][seq_sel_i[2*i +: 2]];
        a_t1[i]  = m_t1[i][seq_sel_i[2*i +: 2]];
        a_t2[i]  = m_t2[i][seq_sel_i[2*i +: 2]];
      end
      pix = 0;
      seen = 1;
    end else if (seen && pix < 4095) pix++;
    if (wr_en_i && wr_sig_i < 3) begin
      m_pol[wr_sig_i][wr_seq_i] = wr_pol_i;
      m_t1[wr_sig_i][wr_seq_i]  = wr_tog1_i;
      m_t2[wr_sig_i][wr_seq_i]  = wr_tog2_i;
    end
    @(negedge clk_i);
    line_start_i = 1'b0;
    wr_en_i      = 1'b0;
    check_pix(tag);
  endtask

  task automatic set_wr(input int s, input int q, input bit p, input int t1, input int t2);
    wr_en_i = 1'b1; wr_sig_i = 2'(s); wr_seq_i = 2'(q);
    wr_pol_i = p; wr_tog1_i = 12'(t1); wr_tog2_i = 12'(t2);
  endtask

  task automatic wr(input string tag, input int s, input int q, input bit p, input int t1, input int t2);
    set_wr(s, q, p, t1, t2);
    tick(tag);
  endtask

  task automatic run(input string tag, input int n);
    for (int k = 0; k < n; k++) tick(tag);
  endtask

  task automatic line(input string tag, input logic [5:0] sel, input int n);
    seq_sel_i = sel;
    line_start_i = 1'b1;
    tick(tag);
    run(tag, n);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog got=timeout exp=completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 3; i++)
      for (int q = 0; q < 4; q++) begin
        m_pol[i][q] = 1'b1; m_t1[i][q] = 4095; m_t2[i][q] = 4095;
      end
    rst_ni = 1'b0; line_start_i = 1'b0; wr_en_i = 1'b0; wr_sig_i = '0; wr_seq_i = '0;
    wr_pol_i = 1'b0; wr_tog1_i = '0; wr_tog2_i = '0; seq_sel_i = '0;
    repeat (3) @(negedge clk_i);
    check("R2", pulse_n_o, 3'b111);
    rst_ni = 1'b1;
    run("R2", 3);

    // directed shapes: window, equal toggles, toggle at pixel 0
    wr("R2", 0, 0, 1'b1, 10, 20);
    wr("R2", 1, 1, 1'b0, 5, 5);
    wr("R2", 2, 2, 1'b1, 0, 4095);
    line("R3/R4/R5/R10", {2'd2, 2'd1, 2'd0}, 30);

    // restart mid-line
    line("R1", {2'd2, 2'd1, 2'd0}, 12);
    line("R1", {2'd2, 2'd1, 2'd0}, 25);

    // select changes mid-line
    line("R7", {2'd2, 2'd1, 2'd0}, 3);
    seq_sel_i = 6'b00_00_11;
    run("R7", 25);

    // mid-line write, then next line
    line("R8", {2'd2, 2'd1, 2'd0}, 3);
    wr("R8", 0, 0, 1'b0, 2, 8);
    run("R8", 25);
    line("R8", {2'd2, 2'd1, 2'd0}, 25);

    // write on the line-start edge
    set_wr(0, 0, 1'b1, 4, 6);
    seq_sel_i = {2'd2, 2'd1, 2'd0};
    line_start_i = 1'b1;
    tick("R8");
    run("R8", 20);
    line("R8", {2'd2, 2'd1, 2'd0}, 20);

    // strobe code 3 is dropped
    wr("R9", 3, 0, 1'b0, 1, 2);
    wr("R9", 3, 1, 1'b0, 3, 3);
    line("R9", 6'b00_01_00, 25);

    // saturation with a toggle at the last pixel
    wr("R6", 0, 3, 1'b0, 100, 4095);
    wr("R6", 1, 3, 1'b1, 4095, 4095);
    line("R6", 6'b11_11_11, 4200);

    // random shapes and selects
    for (int i = 0; i < 3; i++)
      for (int q = 0; q < 4; q++) begin
        int t1, t2;
        t1 = $urandom_range(63);
        t2 = ($urandom_range(3) == 0) ? t1 : $urandom_range(63);
        wr("R4/R5", i, q, 1'($urandom_range(1)), t1, t2);
      end
    for (int n = 0; n < 25; n++)
      line("R3/R4/R5/R10", 6'($urandom_range(63)), $urandom_range(70, 40));

    finished = 1;
    summary();
    $finish;
  end
endmodule